// File: doc/BRIEF.md
# Differential Manchester Line Encoder

This block turns a stream of 5-bit line symbols into a two-level differential Manchester waveform for a single twisted-pair transmitter. Each symbol is sent as five bits, least significant bit first. Every bit starts with a level change, and a bit of value one adds a second change halfway through the bit. Only the presence or absence of changes carries data, so the absolute polarity has no meaning. Timing comes from a half-bit strobe (25 MHz for a 12.5 MBd line) that is sampled in the core clock domain. The encoder takes a new symbol on every tenth strobe and marks that cycle with a load pulse.

The all-ones symbol is reserved to mean silence. While it is being sent, the line goes to its idle state. In multidrop mode the idle line is high impedance, so the driver enable drops. In point-to-point mode the idle line is driven at zero differential, so the driver stays enabled. After a period of silence, the first level driven is always positive.

A test select replaces the data path with one of three transmitter test patterns, each emitting one level per half-bit slot:
- a plain alternation of positive and negative,
- blocks of ten positive and ten negative levels,
- a pseudo-random level sequence produced by a 15-bit maximal-length LFSR.

Top module: `dme_line_encoder`

## Requirements
- R1: With the test select at 00, the block samples `sym_i` on the strobe cycle where `sym_load_o` is high. This pulse comes on the first strobe after reset and on every tenth strobe after that. The ten half-bit slots that follow carry bit 0 first and bit 4 last.
- R2: While data is being driven, the level after the first half-slot of every bit is the opposite of the level before it.
- R3: In the second half-slot of a bit, the level changes if the bit is 1 and stays the same if the bit is 0.
- R4: Symbol 11111 puts `lvl_o` at 00 (idle) for all ten of its half-slots. During idle, `drv_en_o` is 0 when `mdrop_i`=1 and 1 when `mdrop_i`=0.
- R5: The first non-idle level after idle (silence, reset or test mode) is positive. The level encoding is 01 for positive and 10 for negative.
- R6: Test select 01 drives positive, negative, positive, … and changes on each strobe, starting with positive.
- R7: Test select 10 drives ten positive levels and then ten negative levels, one per strobe, and repeats.
- R8: Test select 11 drives, on each strobe, positive if the LFSR's most significant bit is 1 and negative if it is 0. On each step the LFSR shifts left and takes in bit14 XOR bit13 (polynomial x^15+x^14+1). It starts from seed 1 after reset and advances only in this mode.
- R9: In any test mode, `drv_en_o` is 1 once a level is driven, whatever the value of `mdrop_i`. `sym_i` has no effect on the pattern.
- R10: Reset sets `lvl_o` to idle and clears all pattern counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick_i | input | 1 | One-cycle strobe per half-bit period |
| sym_i | input | 5 | Symbol to send, LSB first; 11111 = silence |
| mdrop_i | input | 1 | 1 = multidrop (idle is high impedance), 0 = point-to-point |
| tsel_i | input | 2 | 00 normal, 01 alternate, 10 ten/ten blocks, 11 pseudo-random |
| lvl_o | output | 2 | Line level: 00 idle, 01 positive, 10 negative |
| drv_en_o | output | 1 | Line driver enable |
| sym_load_o | output | 1 | High on the strobe cycle that samples `sym_i` |

## Verification
A slot counter that is out of phase shows up as `sym_load_o` on the wrong strobe and as mid-bit changes read from the wrong symbol. Either one is visible within one symbol time, which is ten strobes. A stale polarity or silence flag gives a wrong level at the first bit edge after silence. A faulty pattern counter or LFSR gives a level that differs from the independently computed sequence. The block-pattern case shows up within twenty strobes, and the pseudo-random case within the first fifteen strobes, when the seed reaches the top bit.

// File: rtl/dme_enc_pkg.sv
package dme_enc_pkg;

  typedef enum logic [1:0] {
    LVL_IDLE = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    TM_OFF   = 2'b00,
    TM_ALT   = 2'b01,
    TM_BLOCK = 2'b10,
    TM_PRBS  = 2'b11
  } tmode_e;

  // Next level after a transition; leaving idle always starts positive.
  function automatic lvl_e lvl_flip(input lvl_e cur);
    case (cur)
      LVL_POS: return LVL_NEG;
      LVL_NEG: return LVL_POS;
      default: return LVL_POS;
    endcase
  endfunction

  function automatic lvl_e lvl_of_bit(input logic b);
    return b ? LVL_POS : LVL_NEG;
  endfunction

endpackage

// File: rtl/dme_slot_ctr.sv
module dme_slot_ctr #(
  parameter int SYM_W  = 5,
  localparam int SLOTS  = 2 * SYM_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(SYM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic             load_w,
  output logic             bit_start_w,
  output logic             mid_w,
  output logic [BIT_W-1:0] bit_idx
);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (!run) begin
      slot_q <= '0;
    end else if (tick) begin
      slot_q <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  assign load_w      = run && tick && (slot_q == '0);
  assign bit_start_w = run && tick && !slot_q[0];
  assign mid_w       = run && tick && slot_q[0];
  assign bit_idx     = BIT_W'(slot_q >> 1);

endmodule

// File: rtl/dme_data_path.sv
module dme_data_path
  import dme_enc_pkg::*;
#(
  parameter int SYM_W = 5,
  localparam int BIT_W = $clog2(SYM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load_w,
  input  logic             bit_start_w,
  input  logic             mid_w,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [SYM_W-1:0] sym_i,
  output lvl_e             lvl,
  output logic             mid_zero_w
);

  logic [SYM_W-1:0] sym_q;
  logic             silent_q;
  logic             cur_bit;

  function automatic logic is_silence(input logic [SYM_W-1:0] s);
    return &s;
  endfunction

  assign cur_bit    = sym_q[bit_idx];
  assign mid_zero_w = mid_w && !silent_q && !cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q    <= '1;
      silent_q <= 1'b1;
      lvl      <= LVL_IDLE;
    end else if (!run) begin
      silent_q <= 1'b1;
      lvl      <= LVL_IDLE;
    end else if (load_w) begin
      sym_q <= sym_i;
      if (is_silence(sym_i)) begin
        silent_q <= 1'b1;
        lvl      <= LVL_IDLE;
      end else begin
        silent_q <= 1'b0;
        lvl      <= lvl_flip(lvl);
      end
    end else if (bit_start_w) begin
      if (!silent_q) lvl <= lvl_flip(lvl);
    end else if (mid_w) begin
      if (!silent_q && cur_bit) lvl <= lvl_flip(lvl);
    end
  end

endmodule

// File: rtl/dme_test_gen.sv
module dme_test_gen
  import dme_enc_pkg::*;
#(
  parameter int          BLOCK_LEN = 10,
  parameter int          PRBS_W    = 15,
  parameter int          PRBS_TAP  = 14,
  parameter logic [14:0] PRBS_SEED = 15'h0001,
  localparam int         CNT_W     = $clog2(2 * BLOCK_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic [1:0] tsel,
  output lvl_e lvl
);

  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRBS_W-1:0] prbs_q;

  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_TAP-1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= LVL_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      prbs_q  <= PRBS_W'(PRBS_SEED);
    end else begin
      if (tsel != TM_ALT)   phase_q <= 1'b0;
      if (tsel != TM_BLOCK) cnt_q   <= '0;
      if (tsel == TM_OFF) begin
        lvl <= LVL_IDLE;
      end else if (tick) begin
        case (tsel)
          TM_ALT: begin
            lvl     <= phase_q ? LVL_NEG : LVL_POS;
            phase_q <= ~phase_q;
          end
          TM_BLOCK: begin
            lvl   <= (cnt_q < CNT_W'(BLOCK_LEN)) ? LVL_POS : LVL_NEG;
            cnt_q <= (cnt_q == CNT_W'(2 * BLOCK_LEN - 1)) ? '0 : cnt_q + 1'b1;
          end
          default: begin
            lvl    <= lvl_of_bit(prbs_q[PRBS_W-1]);
            prbs_q <= prbs_step(prbs_q);
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dme_line_encoder.sv
module dme_line_encoder
  import dme_enc_pkg::*;
#(
  parameter int          SYM_W     = 5,
  parameter int          BLOCK_LEN = 10,
  parameter int          PRBS_W    = 15,
  parameter int          PRBS_TAP  = 14,
  parameter logic [14:0] PRBS_SEED = 15'h0001,
  localparam int         BIT_W     = $clog2(SYM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             mdrop_i,
  input  logic [1:0]       tsel_i,
  output logic [1:0]       lvl_o,
  output logic             drv_en_o,
  output logic             sym_load_o
);

  logic             run_w;
  logic             load_w;
  logic             bit_start_w;
  logic             mid_w;
  logic             mid_zero_w;
  logic [BIT_W-1:0] bit_idx;
  lvl_e             dp_lvl;
  lvl_e             tg_lvl;
  lvl_e             sel_lvl;

  assign run_w = (tsel_i == TM_OFF);

  dme_slot_ctr #(.SYM_W(SYM_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .tick(half_tick_i), .run(run_w),
    .load_w(load_w), .bit_start_w(bit_start_w), .mid_w(mid_w), .bit_idx(bit_idx)
  );

  dme_data_path #(.SYM_W(SYM_W)) data_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .load_w(load_w),
    .bit_start_w(bit_start_w), .mid_w(mid_w), .bit_idx(bit_idx),
    .sym_i(sym_i), .lvl(dp_lvl), .mid_zero_w(mid_zero_w)
  );

  dme_test_gen #(
    .BLOCK_LEN(BLOCK_LEN), .PRBS_W(PRBS_W), .PRBS_TAP(PRBS_TAP), .PRBS_SEED(PRBS_SEED)
  ) test_i (
    .clk(clk), .rst_n(rst_n), .tick(half_tick_i), .tsel(tsel_i), .lvl(tg_lvl)
  );

  assign sel_lvl    = run_w ? dp_lvl : tg_lvl;
  assign lvl_o      = sel_lvl;
  assign drv_en_o   = !((sel_lvl == LVL_IDLE) && mdrop_i);
  assign sym_load_o = load_w;

endmodule

// File: rtl/dme_line_encoder_chk.sv
module dme_line_encoder_chk #(
  parameter int SYM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             half_tick_i,
  input logic [SYM_W-1:0] sym_i,
  input logic [1:0]       tsel_i,
  input logic [1:0]       lvl_o,
  input logic             sym_load_o,
  input logic             run_w,
  input logic             bit_start_w,
  input logic             mid_zero_w
);

  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_w && !half_tick_i) && $past(run_w, 2) && run_w |-> $stable(lvl_o)); // R1

  AST_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bit_start_w) && run_w && $past(run_w) && $past(lvl_o) != 2'b00 && lvl_o != 2'b00
    |-> lvl_o != $past(lvl_o)); // R2

  AST_ZERO_NO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mid_zero_w) && run_w && $past(run_w) |-> $stable(lvl_o)); // R3

  AST_SILENCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sym_load_o && (&sym_i)) && run_w && $past(run_w) |-> lvl_o == 2'b00); // R4

  AST_LEAVE_IDLE_POS: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && $past(run_w) && $past(lvl_o) == 2'b00 && lvl_o != 2'b00 |-> lvl_o == 2'b01); // R5

  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tsel_i == 2'b01 && $past(tsel_i) == 2'b01 && $past(half_tick_i) && $past(lvl_o) != 2'b00
    |-> lvl_o != $past(lvl_o)); // R6

  AST_LEGAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_o != 2'b11); // R10

endmodule

bind dme_line_encoder dme_line_encoder_chk #(.SYM_W(SYM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .half_tick_i(half_tick_i), .sym_i(sym_i),
  .tsel_i(tsel_i), .lvl_o(lvl_o), .sym_load_o(sym_load_o), .run_w(run_w),
  .bit_start_w(bit_start_w), .mid_zero_w(mid_zero_w)
);

// File: tb/dme_line_encoder_tb.sv
module dme_line_encoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       half_tick_i;
  logic [4:0] sym_i;
  logic       mdrop_i;
  logic [1:0] tsel_i;
  logic [1:0] lvl_o;
  logic       drv_en_o;
  logic       sym_load_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  // Bench-side model state
  logic [1:0] m_lvl;
  logic       m_sil;
  logic [4:0] m_sym;
  int         m_slot;
  logic [14:0] m_lfsr;
  logic       ld_seen;

  localparam int NVEC = 8;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_11110, 6'b0_01001, 6'b1_11111, 6'b1_10100,
    6'b0_11111, 6'b0_00111, 6'b1_11000, 6'b1_10001
  };

  always #2.5 clk = ~clk;

  dme_line_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick_i(half_tick_i), .sym_i(sym_i),
    .mdrop_i(mdrop_i), .tsel_i(tsel_i), .lvl_o(lvl_o), .drv_en_o(drv_en_o),
    .sym_load_o(sym_load_o)
  );

  function automatic logic [1:0] m_flip(input logic [1:0] l);
    return (l == 2'b01) ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk);
    half_tick_i = 1'b1;
    #1 ld_seen = sym_load_o;
    @(negedge clk);
    half_tick_i = 1'b0;
    #1;
  endtask

  task automatic send_sym(input logic md, input logic [4:0] s);
    string tag;
    sym_i   = s;
    mdrop_i = md;
    for (int k = 0; k < 10; k++) begin
      do_tick();
      if (m_slot == 0) begin
        m_sym = s;
        if (&s) begin m_sil = 1'b1; m_lvl = 2'b00; tag = "R4"; end
        else begin m_sil = 1'b0; m_lvl = m_flip(m_lvl); tag = "R5"; end
        chk("R1", {1'b0, ld_seen}, 2'b01);
      end else if ((m_slot % 2) == 0) begin
        if (!m_sil) m_lvl = m_flip(m_lvl);
        tag = m_sil ? "R4" : "R2";
        if (k == 2) chk("R1", {1'b0, ld_seen}, 2'b00);
      end else begin
        if (!m_sil && m_sym[m_slot / 2]) m_lvl = m_flip(m_lvl);
        tag = m_sil ? "R4" : "R3";
      end
      m_slot = (m_slot + 1) % 10;
      chk(tag, lvl_o, m_lvl);
      chk("R4", {1'b0, drv_en_o}, {1'b0, !(m_lvl == 2'b00 && md)});
    end
  endtask

  task automatic set_test(input logic [1:0] t);
    @(negedge clk);
    tsel_i = t;
    @(negedge clk);
    #1;
    m_slot = 0; m_lvl = 2'b00; m_sil = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; half_tick_i = 1'b0; sym_i = 5'b0; mdrop_i = 1'b0; tsel_i = 2'b00;
    m_lvl = 2'b00; m_sil = 1'b1; m_sym = 5'b11111; m_slot = 0; m_lfsr = 15'h0001;
    repeat (4) @(negedge clk);
    #1;
    chk("R10", lvl_o, 2'b00);
    chk("R4", {1'b0, drv_en_o}, 2'b01);
    mdrop_i = 1'b1;
    #1 chk("R4", {1'b0, drv_en_o}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;

    // Table-driven normal symbols
    for (int v = 0; v < NVEC; v++) send_sym(VEC[v][5], VEC[v][4:0]);
    send_sym(1'b1, 5'b11111);

    // R6: alternate pattern, symbol input and multidrop ignored (R9)
    set_test(2'b01);
    mdrop_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sym_i = 5'(k * 7);
      do_tick();
      chk("R6", lvl_o, (k % 2 == 0) ? 2'b01 : 2'b10);
      chk("R9", {1'b0, drv_en_o}, 2'b01);
    end
    set_test(2'b00);
    chk("R4", lvl_o, 2'b00);

    // R7: ten/ten blocks
    set_test(2'b10);
    mdrop_i = 1'b0;
    for (int k = 0; k < 45; k++) begin
      sym_i = 5'b11111;
      do_tick();
      chk("R7", lvl_o, ((k % 20) < 10) ? 2'b01 : 2'b10);
    end

    // R8: pseudo-random levels from the bench's own LFSR model
    set_test(2'b11);
    mdrop_i = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [1:0] e;
      e = m_lfsr[14] ? 2'b01 : 2'b10;
      m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
      do_tick();
      chk("R8", lvl_o, e);
      chk("R9", {1'b0, drv_en_o}, 2'b01);
    end

    // R5: back to data after test mode, first driven level positive
    set_test(2'b00);
    send_sym(1'b0, 5'b00000);
    send_sym(1'b0, 5'b11111);
    send_sym(1'b1, 5'b11111);
    send_sym(1'b1, 5'b01011);

    // R10: reset in the middle of a symbol returns to idle and slot 0
    sym_i = 5'b10101;
    do_tick(); do_tick(); do_tick();
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R10", lvl_o, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    m_lvl = 2'b00; m_sil = 1'b1; m_slot = 0;
    send_sym(1'b0, 5'b10101);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule